// File: doc/BRIEF.md
# Colour Channel Selection Sequencer

This block holds the colour-select state of a three-channel (red, green, blue) scanner front end. It drives two registered 2-bit selects. `mux_sel` steers the analog input multiplexer and `reg_sel` picks the active set of offset and gain registers. The colour comes from one of three sources, chosen by a 2-bit mode field: an internal colour code written by software, two external select pins, or a rotation that steps once per scan line.

In the rotating mode, the low external select pin is reused as a line-start input. That pin is synchronised to the sampling clock and rising-edge detected, so each line-start pulse advances the rotation exactly once, however long it stays high. A force option makes the input multiplexer follow its own colour code while the register set still follows the mode. Two write strobes return the rotation to red: a rotation-clear strobe and a software-reset strobe.

Top module: `chan_select_seq`

## Requirements
- R1: Colour codes on `mux_sel` and `reg_sel` are 2'b00 red, 2'b01 green, 2'b10 blue, and neither output ever shows 2'b11. Both outputs are registered and show the selection made from the inputs present at the previous clock edge.
- R2: With `mode` = 2'b00 (internal), `reg_sel` follows `int_code`, and an `int_code` of 2'b11 gives red.
- R3: With `mode` = 2'b01 (external), `reg_sel` follows `ext_sel[1:0]`, and an `ext_sel` of 2'b11 gives red.
- R4: With `mode` = 2'b10 (rotating), `reg_sel` shows the rotation state. That state steps red, then green, then blue, then back to red, once per rising edge of `ext_sel[0]`. A pulse held high for many cycles gives one step, and the new value reaches the output by the fourth clock edge after the pin rises.
- R5: Outside the rotating mode, the rotation state holds: activity on `ext_sel[0]` does not advance it. It is seen unchanged on `reg_sel` after returning to `mode` = 2'b10.
- R6: In the rotating mode, `ext_sel[1]` has no effect on either output.
- R7: A one-cycle `cyc_clr` strobe returns the rotation to red. If it is sampled on the same edge as a detected line-start edge, the clear wins and the rotation ends at red. A clear one edge before a line-start edge leaves the rotation at green.
- R8: While `rst` is high, both outputs are red and the rotation is red. A one-cycle `sw_rst` strobe also returns the rotation to red.
- R9: With `force_en` high, `mux_sel` follows `force_code` (2'b11 gives red) and `reg_sel` still follows the mode.
- R10: With `mode` = 2'b11, `reg_sel` is red.
- R11: With `force_en` low, `mux_sel` equals `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Selection mode: 00 internal, 01 external, 10 rotating, 11 red |
| int_code | input | 2 | Internal colour code |
| force_en | input | 1 | Input multiplexer follows `force_code` when high |
| force_code | input | 2 | Colour code for the input multiplexer under force |
| ext_sel | input | 2 | External select pins; bit 0 is the line-start input in rotating mode |
| cyc_clr | input | 1 | One-cycle strobe that returns the rotation to red |
| sw_rst | input | 1 | One-cycle software reset strobe for the rotation |
| mux_sel | output | 2 | Input multiplexer colour select |
| reg_sel | output | 2 | Offset and gain register set select |

## Verification
A rotation clear and a detected line-start edge can reach the rotation register on the same clock edge. The bench provokes this by raising the pin and then asserting `cyc_clr` exactly two falling edges later, so both are sampled on one rising edge. The result must be red, because the clear has priority. A second directed case moves the clear one edge earlier, and the result must be green, which shows that the clear and the step were applied in that order. Random runs also mix pulses of varied length, clears, force settings and changes on the unused pin, and compare the outputs against a bench model of the rotation.

// File: rtl/chan_select_pkg.sv
package chan_select_pkg;

  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    COL_RED   = 2'b00,
    COL_GREEN = 2'b01,
    COL_BLUE  = 2'b10
  } colour_t;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'b00,
    SRC_EXTERNAL = 2'b01,
    SRC_ROTATE   = 2'b10,
    SRC_UNUSED   = 2'b11
  } src_mode_t;

  // Map a raw 2-bit code to a legal colour; the spare code reads as red.
  function automatic colour_t legal_colour(input logic [CODE_W-1:0] raw);
    colour_t c;
    case (raw)
      2'b01:   c = COL_GREEN;
      2'b10:   c = COL_BLUE;
      default: c = COL_RED;
    endcase
    return c;
  endfunction

  function automatic colour_t step_colour(input colour_t cur);
    colour_t c;
    case (cur)
      COL_RED:   c = COL_GREEN;
      COL_GREEN: c = COL_BLUE;
      default:   c = COL_RED;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ccs_line_edge.sv
module ccs_line_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ccs_rotator.sv
module ccs_rotator
  import chan_select_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clear,
  input  logic    advance,
  output colour_t rot
);

  colour_t rot_q;

  // Clear outranks a step that lands on the same edge.
  always_ff @(posedge clk) begin
    if (rst || clear) rot_q <= COL_RED;
    else if (advance) rot_q <= step_colour(rot_q);
  end

  assign rot = rot_q;

endmodule

// File: rtl/ccs_pick.sv
module ccs_pick
  import chan_select_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] int_code,
  input  logic [CODE_W-1:0] ext_code,
  input  colour_t           rot,
  input  logic              force_en,
  input  logic [CODE_W-1:0] force_code,
  output colour_t           reg_pick,
  output colour_t           mux_pick
);

  always_comb begin
    case (src_mode_t'(mode))
      SRC_INTERNAL: reg_pick = legal_colour(int_code);
      SRC_EXTERNAL: reg_pick = legal_colour(ext_code);
      SRC_ROTATE:   reg_pick = rot;
      default:      reg_pick = COL_RED;
    endcase
    mux_pick = force_en ? legal_colour(force_code) : reg_pick;
  end

endmodule

// File: rtl/chan_select_seq.sv
module chan_select_seq
  import chan_select_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode,
  input  logic [1:0]  int_code,
  input  logic        force_en,
  input  logic [1:0]  force_code,
  input  logic [1:0]  ext_sel,
  input  logic        cyc_clr,
  input  logic        sw_rst,
  output logic [1:0]  mux_sel,
  output logic [1:0]  reg_sel
);

  logic    line_rise;
  logic    rot_step;
  colour_t rot;
  colour_t reg_pick;
  colour_t mux_pick;
  colour_t reg_q;
  colour_t mux_q;

  ccs_line_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_sel[0]),
    .rise (line_rise)
  );

  assign rot_step = line_rise && (src_mode_t'(mode) == SRC_ROTATE);

  ccs_rotator u_rot (
    .clk     (clk),
    .rst     (rst),
    .clear   (cyc_clr | sw_rst),
    .advance (rot_step),
    .rot     (rot)
  );

  ccs_pick u_pick (
    .mode       (mode),
    .int_code   (int_code),
    .ext_code   (ext_sel),
    .rot        (rot),
    .force_en   (force_en),
    .force_code (force_code),
    .reg_pick   (reg_pick),
    .mux_pick   (mux_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= COL_RED;
      mux_q <= COL_RED;
    end else begin
      reg_q <= reg_pick;
      mux_q <= mux_pick;
    end
  end

  assign reg_sel = reg_q;
  assign mux_sel = mux_q;

endmodule

// File: rtl/chan_select_seq_chk.sv
module chan_select_seq_chk
  import chan_select_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [1:0] int_code,
  input logic       force_en,
  input logic [1:0] force_code,
  input logic [1:0] ext_sel,
  input logic       cyc_clr,
  input logic [1:0] mux_sel,
  input logic [1:0] reg_sel
);

  assert_legal_codes_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_sel != 2'b11) && (mux_sel != 2'b11));

  assert_internal_src_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (reg_sel == legal_colour($past(int_code))));

  assert_external_src_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (reg_sel == legal_colour($past(ext_sel))));

  assert_rotate_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) ##1 (mode == 2'b10) |=>
      ((reg_sel == $past(reg_sel)) ||
       (reg_sel == step_colour(colour_t'($past(reg_sel)))) ||
       (reg_sel == 2'b00)));

  assert_clear_red_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc_clr && mode == 2'b10) ##1 (mode == 2'b10) |=> (reg_sel == 2'b00));

  assert_reset_red_R8: assert property (@(posedge clk)
    rst |=> ((reg_sel == 2'b00) && (mux_sel == 2'b00)));

  assert_force_mux_R9: assert property (@(posedge clk) disable iff (rst)
    force_en |=> (mux_sel == legal_colour($past(force_code))));

  assert_spare_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (reg_sel == 2'b00));

  assert_follow_reg_R11: assert property (@(posedge clk) disable iff (rst)
    !force_en |=> (mux_sel == reg_sel));

endmodule

bind chan_select_seq chan_select_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .int_code   (int_code),
  .force_en   (force_en),
  .force_code (force_code),
  .ext_sel    (ext_sel),
  .cyc_clr    (cyc_clr),
  .mux_sel    (mux_sel),
  .reg_sel    (reg_sel)
);

// File: tb/chan_select_seq_test.sv
`timescale 1ns/1ps
module chan_select_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] int_code = 2'b00;
  logic       force_en = 1'b0;
  logic [1:0] force_code = 2'b00;
  logic [1:0] ext_sel = 2'b00;
  logic       cyc_clr = 1'b0;
  logic       sw_rst = 1'b0;
  logic [1:0] mux_sel;
  logic [1:0] reg_sel;

  int checks = 0;
  int fails  = 0;
  int exp_rot = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_select_seq uut (
    .clk(clk), .rst(rst), .mode(mode), .int_code(int_code),
    .force_en(force_en), .force_code(force_code), .ext_sel(ext_sel),
    .cyc_clr(cyc_clr), .sw_rst(sw_rst), .mux_sel(mux_sel), .reg_sel(reg_sel)
  );

  function automatic logic [1:0] fix(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  function automatic logic [1:0] want_reg(input logic [1:0] m, input logic [1:0] ic,
                                          input logic [1:0] ec, input int r);
    case (m)
      2'b00:   return fix(ic);
      2'b01:   return fix(ec);
      2'b10:   return 2'(r);
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] want_mux(input logic fe, input logic [1:0] fc,
                                          input logic [1:0] rg);
    return fe ? fix(fc) : rg;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_both(input string tag);
    logic [1:0] er;
    er = want_reg(mode, int_code, ext_sel, exp_rot);
    check({tag, " reg_sel"}, reg_sel, er);
    check({tag, " mux_sel"}, mux_sel, want_mux(force_en, force_code, er));
  endtask

  task automatic line_pulse(input int hold);
    ext_sel[0] = 1'b1;
    repeat (hold) @(negedge clk);
    ext_sel[0] = 1'b0;
    repeat (5) @(negedge clk);
    exp_rot = (exp_rot + 1) % 3;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    int_code = 2'b01;
    repeat (3) @(negedge clk);
    check("R8 reset reg_sel", reg_sel, 2'b00);
    check("R8 reset mux_sel", mux_sel, 2'b00);
    rst = 1'b0;
    @(negedge clk);

    // R2 internal mode, every code
    mode = 2'b00;
    for (int c = 0; c < 4; c++) begin
      int_code = 2'(c);
      @(negedge clk);
      check_both("R2 internal");
    end
    // R3 external mode, every code
    mode = 2'b01;
    for (int c = 0; c < 4; c++) begin
      ext_sel = 2'(c);
      @(negedge clk);
      check_both("R3 external");
    end
    // R10 spare mode
    mode = 2'b11; int_code = 2'b10; ext_sel = 2'b10;
    @(negedge clk);
    check("R10 spare mode", reg_sel, 2'b00);
    check("R11 spare mode mux", mux_sel, 2'b00);
    // R9 force with each force code
    mode = 2'b00; int_code = 2'b10; force_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      force_code = 2'(c);
      @(negedge clk);
      check("R9 force mux", mux_sel, fix(2'(c)));
      check("R9 force reg", reg_sel, 2'b10);
    end
    force_en = 1'b0;

    // Random non-rotating traffic
    for (int i = 0; i < 150; i++) begin
      int pick = $urandom_range(0, 2);
      mode = (pick == 2) ? 2'b11 : 2'(pick);
      int_code = 2'($urandom_range(0, 3));
      ext_sel = 2'($urandom_range(0, 3));
      force_en = 1'($urandom_range(0, 1));
      force_code = 2'($urandom_range(0, 3));
      @(negedge clk);
      check_both("R2 R3 R9 R10 R11 random");
    end
    force_en = 1'b0;
    ext_sel = 2'b00;
    repeat (5) @(negedge clk);

    // R4 rotation
    mode = 2'b10;
    repeat (2) @(negedge clk);
    check("R4 enter rotate red", reg_sel, 2'b00);
    line_pulse(1);
    check("R4 step green", reg_sel, 2'b01);
    line_pulse(12);
    check("R4 long pulse one step blue", reg_sel, 2'b10);
    line_pulse(2);
    check("R4 wrap red", reg_sel, 2'b00);
    line_pulse(3);
    check("R4 step green again", reg_sel, 2'b01);

    // R5 rotation held outside rotating mode
    mode = 2'b01;
    for (int k = 0; k < 3; k++) begin
      ext_sel[0] = 1'b1; repeat (3) @(negedge clk);
      ext_sel[0] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    mode = 2'b10;
    repeat (2) @(negedge clk);
    check("R5 rotation held", reg_sel, 2'b01);

    // R6 high pin ignored in rotating mode
    for (int k = 0; k < 4; k++) begin
      ext_sel[1] = ~ext_sel[1];
      repeat (2) @(negedge clk);
      check("R6 ext_sel[1] ignored reg", reg_sel, 2'b01);
      check("R6 ext_sel[1] ignored mux", mux_sel, 2'b01);
    end
    ext_sel[1] = 1'b0;

    // R7 plain clear
    cyc_clr = 1'b1; @(negedge clk); cyc_clr = 1'b0;
    @(negedge clk);
    exp_rot = 0;
    check("R7 clear to red", reg_sel, 2'b00);

    // R7 clear and line edge on the same edge: clear wins
    line_pulse(1);
    check("R7 pre-collision green", reg_sel, 2'b01);
    ext_sel[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    cyc_clr = 1'b1; @(negedge clk); cyc_clr = 1'b0;
    ext_sel[0] = 1'b0;
    repeat (5) @(negedge clk);
    exp_rot = 0;
    check("R7 collision clear wins", reg_sel, 2'b00);

    // R7 clear one edge before the line edge: clear then step
    ext_sel[0] = 1'b1;
    @(negedge clk);
    cyc_clr = 1'b1; @(negedge clk); cyc_clr = 1'b0;
    ext_sel[0] = 1'b0;
    repeat (5) @(negedge clk);
    exp_rot = 1;
    check("R7 early clear then step green", reg_sel, 2'b01);

    // R8 software reset
    line_pulse(2);
    check("R8 pre-soft-reset blue", reg_sel, 2'b10);
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    @(negedge clk);
    exp_rot = 0;
    check("R8 soft reset red", reg_sel, 2'b00);

    // Random rotating traffic
    for (int i = 0; i < 120; i++) begin
      int act = $urandom_range(0, 3);
      force_en = 1'($urandom_range(0, 1));
      force_code = 2'($urandom_range(0, 3));
      ext_sel[1] = 1'($urandom_range(0, 1));
      if (act <= 1) begin
        line_pulse($urandom_range(1, 6));
      end else if (act == 2) begin
        cyc_clr = 1'b1; @(negedge clk); cyc_clr = 1'b0;
        @(negedge clk);
        exp_rot = 0;
      end else begin
        @(negedge clk);
      end
      check_both("R4 R6 R7 R9 rotate random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule